// File: doc/BRIEF.md
# Register File with Stack Pointer

This block holds the working registers of a small processor core. It has 32 entries of 32 bits. Two read ports, A and B, are combinational and can select any entry at the same time. One write port stores a word on the rising clock edge. Each port is addressed by a 5-bit select.

Entries 0 to 27 are ordinary full-width registers. Entries 28, 29 and 30 are index registers. They keep only a narrow low field, 16 bits by default, and read back with the upper bits at zero. Entry 31 is the stack pointer. It has its own reset value and two strobes that step it up or down by one, with no write cycle needed.

The surrounding core places a register number on each read select and reads the operands straight away. It returns a result through the write port. It pulses the stack strobes during push and pop sequences.

Top module: `rfsp_top`

## Requirements
- R1: When `rst` is high at a rising clock edge, entries 0 to 30 become zero and entry 31 becomes 0xFFFFFE00. Reset is synchronous and active high.
- R2: When `wr_en` is high at a rising edge, the word on `wr_data` is stored into the entry selected by `wr_sel`. For entries 0 to 27 the full 32 bits are stored.
- R3: Entries 28, 29 and 30 store only bits [15:0] of the written word. They always read back with bits [31:16] equal to zero.
- R4: When `sp_inc` is high at an edge and `sp_dec` is low, entry 31 increases by 1.
- R5: When `sp_dec` is high at an edge and `sp_inc` is low, entry 31 decreases by 1.
- R6: When `sp_inc` and `sp_dec` are both high at an edge, entry 31 keeps its value.
- R7: A write to entry 31 loads `wr_data` into the stack pointer and overrides any increment or decrement in the same cycle.
- R8: Reset overrides writes and stack strobes in the same cycle.
- R9: Incrementing 0xFFFFFFFF gives 0x00000000. Decrementing 0x00000000 gives 0xFFFFFFFF.
- R10: Each read port shows the selected entry with no clock latency. Both ports give identical data for the same select. While an entry is being written, a read of that entry shows the old value until the edge has passed.
- R11: When `wr_en` is low, no entry other than the stack pointer changes, whatever `wr_sel` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Entry number for the write |
| wr_data | input | 32 | Word to write |
| sp_inc | input | 1 | Stack pointer step-up strobe |
| sp_dec | input | 1 | Stack pointer step-down strobe |
| rd_a_sel | input | 5 | Entry number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 5 | Entry number for read port B |
| rd_b_data | output | 32 | Read port B data |

## Verification
The stack pointer can be loaded by the write port and stepped by a strobe in the same cycle. The two strobes can also arrive together. The bench causes both cases on purpose:
- It raises `wr_en` with `wr_sel` at 31 while `sp_inc` is high, and expects the written word to win.
- It raises both strobes at once and expects the pointer to hold.

A third clash is also tested: reset raised together with a write and a strobe, where reset must win. In every case the result is read back through both read ports after the edge.

// File: rtl/rfsp_pkg.sv
package rfsp_pkg;
   typedef enum logic [1:0] {
      SP_HOLD = 2'd0,
      SP_UP   = 2'd1,
      SP_DOWN = 2'd2,
      SP_LOAD = 2'd3
   } sp_op_e;

   function automatic sp_op_e sp_decide(logic load, logic up, logic down);
      if (load)
         return SP_LOAD;
      else if (up && !down)
         return SP_UP;
      else if (down && !up)
         return SP_DOWN;
      else
         return SP_HOLD;
   endfunction
endpackage

// File: rtl/rfsp_entry.sv
module rfsp_entry #(
   parameter int DATA_W = 32,
   parameter int KEEP_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [KEEP_W-1:0] d,
   output logic [DATA_W-1:0] rd
);
   logic [KEEP_W-1:0] q;

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (we)
         q <= d;
   end

   generate
      if (KEEP_W == DATA_W) begin : g_full
         assign rd = q;
      end else begin : g_narrow
         assign rd = {{(DATA_W-KEEP_W){1'b0}}, q};
      end
   endgenerate

   assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(rd));
   assert_store_R2: assert property (@(posedge clk) disable iff (rst)
      we |=> rd[KEEP_W-1:0] == $past(d));
endmodule

// File: rtl/rfsp_stack.sv
module rfsp_stack
   import rfsp_pkg::*;
#(
   parameter int              DATA_W  = 32,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  sp_op_e            op,
   input  logic [DATA_W-1:0] ld_val,
   output logic [DATA_W-1:0] sp
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   always_ff @(posedge clk) begin
      if (rst)
         sp <= RST_VAL;
      else begin
         case (op)
            SP_LOAD: sp <= ld_val;
            SP_UP:   sp <= sp + ONE;
            SP_DOWN: sp <= sp - ONE;
            default: sp <= sp;
         endcase
      end
   end

   assert_sp_up_R4: assert property (@(posedge clk) disable iff (rst)
      op == SP_UP |=> sp == $past(sp) + ONE);
   assert_sp_down_R5: assert property (@(posedge clk) disable iff (rst)
      op == SP_DOWN |=> sp == $past(sp) - ONE);
   assert_sp_hold_R6: assert property (@(posedge clk) disable iff (rst)
      op == SP_HOLD |=> $stable(sp));
   assert_sp_load_R7: assert property (@(posedge clk) disable iff (rst)
      op == SP_LOAD |=> sp == $past(ld_val));
endmodule

// File: rtl/rfsp_rdmux.sv
module rfsp_rdmux #(
   parameter int DATA_W = 32,
   parameter int NREG   = 32,
   parameter int ADDR_W = 5
) (
   input  logic [NREG-1:0][DATA_W-1:0] words,
   input  logic [ADDR_W-1:0]           sel,
   output logic [DATA_W-1:0]           data
);
   assign data = words[sel];
endmodule

// File: rtl/rfsp_top.sv
module rfsp_top
   import rfsp_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 5,
   parameter int                NARROW_W = 16,
   parameter int                IDX_LO   = 28,
   parameter int                IDX_HI   = 30,
   parameter logic [DATA_W-1:0] SP_RST   = 32'hFFFF_FE00
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              sp_inc,
   input  logic              sp_dec,
   input  logic [ADDR_W-1:0] rd_a_sel,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [ADDR_W-1:0] rd_b_sel,
   output logic [DATA_W-1:0] rd_b_data
);
   localparam int NREG   = 1 << ADDR_W;
   localparam int SP_IDX = NREG - 1;

   generate
      if (NARROW_W < 1 || NARROW_W > DATA_W) begin : g_bad_narrow
         $error("NARROW_W must lie in 1..DATA_W");
      end
      if (IDX_LO > IDX_HI || IDX_HI >= SP_IDX) begin : g_bad_index
         $error("index range must lie below the stack pointer entry");
      end
   endgenerate

   logic [NREG-1:0][DATA_W-1:0] words;
   logic [NREG-1:0]             we;
   sp_op_e                      sp_op;

   always_comb begin
      for (int k = 0; k < NREG; k++)
         we[k] = wr_en && (wr_sel == ADDR_W'(k));
   end

   assign sp_op = sp_decide(we[SP_IDX], sp_inc, sp_dec);

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_ent
         if (g == SP_IDX) begin : g_sp
            rfsp_stack #(.DATA_W(DATA_W), .RST_VAL(SP_RST)) u_sp (
               .clk(clk), .rst(rst), .op(sp_op), .ld_val(wr_data),
               .sp(words[g]));
         end else if (g >= IDX_LO && g <= IDX_HI) begin : g_idx
            rfsp_entry #(.DATA_W(DATA_W), .KEEP_W(NARROW_W)) u_reg (
               .clk(clk), .rst(rst), .we(we[g]),
               .d(wr_data[NARROW_W-1:0]), .rd(words[g]));
         end else begin : g_gp
            rfsp_entry #(.DATA_W(DATA_W), .KEEP_W(DATA_W)) u_reg (
               .clk(clk), .rst(rst), .we(we[g]),
               .d(wr_data), .rd(words[g]));
         end
      end
   endgenerate

   rfsp_rdmux #(.DATA_W(DATA_W), .NREG(NREG), .ADDR_W(ADDR_W)) u_rd_a (
      .words(words), .sel(rd_a_sel), .data(rd_a_data));
   rfsp_rdmux #(.DATA_W(DATA_W), .NREG(NREG), .ADDR_W(ADDR_W)) u_rd_b (
      .words(words), .sel(rd_b_sel), .data(rd_b_data));

   assert_ports_agree_R10: assert property (@(posedge clk) disable iff (rst)
      rd_a_sel == rd_b_sel |-> rd_a_data == rd_b_data);

   generate
      if (NARROW_W < DATA_W) begin : g_idx_chk
         assert_idx_upper_R3: assert property (@(posedge clk) disable iff (rst)
            (int'(rd_a_sel) >= IDX_LO && int'(rd_a_sel) <= IDX_HI)
            |-> rd_a_data[DATA_W-1:NARROW_W] == '0);
      end
   endgenerate
endmodule

// File: tb/sim_rfsp_top.sv
module sim_rfsp_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        sp_inc = 1'b0;
   logic        sp_dec = 1'b0;
   logic [4:0]  rd_a_sel = '0;
   logic [4:0]  rd_b_sel = '0;
   logic [31:0] rd_a_data, rd_b_data;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   rfsp_top u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .sp_inc(sp_inc), .sp_dec(sp_dec),
      .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
      .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data));

   // {select, written word, expected read}
   localparam int NVEC = 8;
   localparam logic [68:0] VEC [NVEC] = '{
      {5'd0,  32'h1234_5678, 32'h1234_5678},
      {5'd5,  32'h9ABC_DEF0, 32'h9ABC_DEF0},
      {5'd27, 32'h8000_0001, 32'h8000_0001},
      {5'd28, 32'hCAFE_F00D, 32'h0000_F00D},
      {5'd29, 32'hFFFF_FFFF, 32'h0000_FFFF},
      {5'd30, 32'h0001_0000, 32'h0000_0000},
      {5'd13, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
      {5'd1,  32'hFFFF_FFFF, 32'hFFFF_FFFF}
   };

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd_both(string req, logic [4:0] sel, logic [31:0] exp);
      rd_a_sel = sel;
      rd_b_sel = sel;
      #1;
      chk({req, " port A"}, rd_a_data, exp);
      chk({req, " port B"}, rd_b_data, exp);
   endtask

   task automatic wr(logic [4:0] sel, logic [31:0] d);
      wr_en = 1'b1;
      wr_sel = sel;
      wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   initial begin
      step();
      step();
      rst = 1'b0;
      // R1: reset state of every entry
      for (int i = 0; i < 31; i++)
         rd_both("R1", 5'(i), 32'h0);
      rd_both("R1 sp", 5'd31, 32'hFFFF_FE00);

      // R2 and R3: vector table
      for (int v = 0; v < NVEC; v++) begin
         wr(VEC[v][68:64], VEC[v][63:32]);
         rd_both(VEC[v][68:64] >= 28 ? "R3" : "R2", VEC[v][68:64], VEC[v][31:0]);
      end

      // R10: read during write shows the old value until the edge
      wr_en = 1'b1; wr_sel = 5'd5; wr_data = 32'h1111_2222;
      rd_both("R10 old", 5'd5, 32'h9ABC_DEF0);
      step();
      wr_en = 1'b0;
      rd_both("R10 new", 5'd5, 32'h1111_2222);
      rd_a_sel = 5'd0; rd_b_sel = 5'd27; #1;
      chk("R10 split A", rd_a_data, 32'h1234_5678);
      chk("R10 split B", rd_b_data, 32'h8000_0001);

      // R11: write enable low leaves the entry alone
      wr_en = 1'b0; wr_sel = 5'd0; wr_data = 32'hBAD0_BAD0;
      step();
      rd_both("R11", 5'd0, 32'h1234_5678);

      // R4: three increments
      sp_inc = 1'b1;
      repeat (3) step();
      sp_inc = 1'b0;
      rd_both("R4", 5'd31, 32'hFFFF_FE03);
      // R5: one decrement
      sp_dec = 1'b1; step(); sp_dec = 1'b0;
      rd_both("R5", 5'd31, 32'hFFFF_FE02);
      // R6: both strobes hold
      sp_inc = 1'b1; sp_dec = 1'b1; step(); sp_inc = 1'b0; sp_dec = 1'b0;
      rd_both("R6", 5'd31, 32'hFFFF_FE02);
      // R7: write beats increment
      sp_inc = 1'b1;
      wr(5'd31, 32'hFFFF_FFFF);
      sp_inc = 1'b0;
      rd_both("R7", 5'd31, 32'hFFFF_FFFF);
      // R9: wrap up, then down
      sp_inc = 1'b1; step(); sp_inc = 1'b0;
      rd_both("R9 up", 5'd31, 32'h0000_0000);
      sp_dec = 1'b1; step(); sp_dec = 1'b0;
      rd_both("R9 down", 5'd31, 32'hFFFF_FFFF);

      // R8: reset beats write and strobe
      rst = 1'b1; sp_dec = 1'b1;
      wr(5'd0, 32'h5555_AAAA);
      rst = 1'b0; sp_dec = 1'b0;
      rd_both("R8 reg", 5'd0, 32'h0);
      rd_both("R8 sp", 5'd31, 32'hFFFF_FE00);
      rd_both("R8 idx", 5'd28, 32'h0);

      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule